// File: doc/BRIEF.md
# Programmable qualified event counter

This block is a performance-monitoring counter that software configures through a control register. In each clock cycle it is offered two kinds of activity. One is a generic event, made of an 8-bit code, a set of sub-event bits and a small count of how many times that event fired in the cycle. The other is a tagged cache lookup, made of a valid bit, a one-hot line state and a one-hot request type. The control register picks one event code and a unit mask. The matched per-cycle count then passes through a qualifier and the result is added to a 48-bit counter.

The qualifier has three forms. With a zero threshold, the counter adds the per-cycle count, so an occupancy-style event adds up cycles weighted by the number of pending requests. With a nonzero threshold, the counter adds one in each cycle where the count reaches the threshold. The invert bit turns that compare into "strictly below". In edge mode, the counter adds one only when the qualified condition goes from false to true. Software can read and write both the counter and the control register. There is no interrupt and no chaining to another counter.

Top module: `qual_event_counter`

## Requirements
- R1: After reset, both the counter and the control register read zero.
- R2: A generic event is counted only when its code equals the selected code, the selected code is not 0x34, and its sub-event bits share at least one set bit with the unit mask. In every other cycle the per-cycle count is zero.
- R3: With the threshold at zero and edge mode off, the counter adds the per-cycle count in every enabled cycle.
- R4: With a nonzero threshold, the counter adds 1 in each cycle where the per-cycle count is greater than or equal to the threshold, and adds 0 in every other cycle.
- R5: With the invert bit set and a nonzero threshold, the counter adds 1 in each cycle where the per-cycle count is strictly less than the threshold. With a zero threshold the invert bit has no effect.
- R6: In edge mode, the counter adds 1 only in a cycle where the qualified condition is true and was false in the previous enabled cycle. With a zero threshold, the condition is "per-cycle count is nonzero".
- R7: With code 0x34 selected, a valid lookup adds 1 to the per-cycle count only when both of these hold: its line state (bit 0 M, bit 1 E, bit 2 S, bit 3 I) overlaps unit-mask bits 3:0, and its request type (bit 0 read, bit 1 write, bit 2 external snoop, bit 3 any) overlaps unit-mask bits 7:4. A mask without line-state bits therefore counts nothing.
- R8: A write to the counter loads the written value on the next edge. In the same cycle it takes priority over any increment.
- R9: While the enable bit is clear, the counter holds its value and the edge history is cleared, so the first true cycle after re-enabling counts as an edge.
- R10: The counter wraps modulo 2^48 without any other effect.
- R11: The control register reads back what was written. Its fields are: bits 7:0 event code, 15:8 unit mask, 16 edge, 17 invert, 18 enable, 23:19 threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 24 | Control register write data |
| cfg_rdata | output | 24 | Control register read data |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 48 | Counter write data |
| cnt_rdata | output | 48 | Counter read data |
| ev_code | input | 8 | Code of the generic event offered this cycle |
| ev_sub | input | 8 | Sub-event bits of the generic event |
| ev_count | input | 4 | Occurrences of the generic event this cycle |
| lk_valid | input | 1 | A cache lookup is offered this cycle |
| lk_state | input | 4 | One-hot line state of the lookup |
| lk_req | input | 4 | One-hot request type of the lookup |

## Verification
The bench sweeps every combination of invert and edge against thresholds of 0, 1, 3, 8, 15 and 16. It uses count sequences that hold values over several cycles and that include mismatching codes and non-overlapping sub-events. A design that compared with the wrong strictness, or ignored the invert bit, or applied it at a zero threshold, would end with the wrong totals. So would a design that re-counted while an edge condition stayed true. All 256 unit masks are run against all 16 lookup state and request pairs, which catches a design that lets a request-type filter count on its own. Write priority, the 48-bit wrap, and re-arming the edge detector after a disable are each checked in isolation; an implementation that kept stale history would miss the post-enable edge.

// File: rtl/qual_event_counter.sv
module qual_event_counter #(
  parameter int CNT_W = 48,
  parameter int EVC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [23:0]      cfg_wdata,
  output logic [23:0]      cfg_rdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_rdata,
  input  logic [7:0]       ev_code,
  input  logic [7:0]       ev_sub,
  input  logic [EVC_W-1:0] ev_count,
  input  logic             lk_valid,
  input  logic [3:0]       lk_state,
  input  logic [3:0]       lk_req
);
  localparam int N_W = EVC_W + 1;
  localparam logic [7:0] LOOKUP_CODE = 8'h34;

  logic [23:0]      cfg;
  logic [CNT_W-1:0] count;
  logic             prev_cond;

  wire [7:0] sel    = cfg[7:0];
  wire [7:0] umask  = cfg[15:8];
  wire       edg    = cfg[16];
  wire       inv    = cfg[17];
  wire       en     = cfg[18];
  wire [4:0] thresh = cfg[23:19];

  wire gen_hit = (sel != LOOKUP_CODE) && (ev_code == sel) && ((ev_sub & umask) != 8'd0);
  wire lk_hit  = (sel == LOOKUP_CODE) && lk_valid &&
                 ((lk_state & umask[3:0]) != 4'd0) && ((lk_req & umask[7:4]) != 4'd0);

  logic [N_W-1:0] n;
  assign n = (gen_hit ? N_W'(ev_count) : '0) + N_W'(lk_hit);

  logic cond;
  always_comb begin
    if (thresh == 5'd0)      cond = (n != '0);
    else if (inv)            cond = int'(n) <  int'(thresh);
    else                     cond = int'(n) >= int'(thresh);
  end

  logic [CNT_W-1:0] inc;
  always_comb begin
    if (edg)                 inc = CNT_W'(cond && !prev_cond);
    else if (thresh != 5'd0) inc = CNT_W'(cond);
    else                     inc = CNT_W'(n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg       <= '0;
      count     <= '0;
      prev_cond <= 1'b0;
    end else begin
      if (cfg_we) cfg <= cfg_wdata;
      prev_cond <= en ? cond : 1'b0;
      if (cnt_we)  count <= cnt_wdata;
      else if (en) count <= count + inc;
    end
  end

  assign cfg_rdata = cfg;
  assign cnt_rdata = count;

  // R8
  sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt_rdata == $past(cnt_wdata));

  // R9
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_we) |=> $stable(cnt_rdata));

  // R9
  history_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !prev_cond);

  // R4 R6
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cnt_we && (edg || thresh != 5'd0)) |=> (cnt_rdata - $past(cnt_rdata)) <= CNT_W'(1));
endmodule

// File: tb/qual_event_counter_test.sv
module qual_event_counter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [23:0] cfg_wdata = '0;
  logic [23:0] cfg_rdata;
  logic        cnt_we = 1'b0;
  logic [47:0] cnt_wdata = '0;
  logic [47:0] cnt_rdata;
  logic [7:0]  ev_code = '0;
  logic [7:0]  ev_sub = '0;
  logic [3:0]  ev_count = '0;
  logic        lk_valid = 1'b0;
  logic [3:0]  lk_state = '0;
  logic [3:0]  lk_req = '0;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  qual_event_counter uut (.*);

  task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] pack(logic [7:0] sel, logic [7:0] um, bit edg, bit inv, bit en, logic [4:0] th);
    return {th, en, inv, edg, um, sel};
  endfunction

  task automatic wcfg(logic [23:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wcnt(logic [47:0] v);
    cnt_we = 1'b1; cnt_wdata = v;
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  task automatic idle();
    ev_code = '0; ev_sub = '0; ev_count = '0;
    lk_valid = 1'b0; lk_state = '0; lk_req = '0;
  endtask

  task automatic gstep(logic [7:0] code, logic [7:0] sub, logic [3:0] c);
    ev_code = code; ev_sub = sub; ev_count = c;
    @(negedge clk);
  endtask

  task automatic start(logic [23:0] v);
    idle();
    wcfg(v & ~24'h040000);
    wcnt('0);
    wcfg(v);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 count", cnt_rdata, '0);
    chk("R1 cfg", {24'd0, cfg_rdata}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11
    wcfg(pack(8'h5A, 8'hC3, 1, 0, 0, 5'd21));
    chk("R11 readback", {24'd0, cfg_rdata}, {24'd0, 5'd21, 1'b0, 1'b0, 1'b1, 8'hC3, 8'h5A});

    // R2 mismatching code and non-overlapping sub-events
    start(pack(8'h80, 8'h0F, 0, 0, 1, 0));
    gstep(8'h81, 8'h0F, 4'd9);
    gstep(8'h80, 8'hF0, 4'd9);
    gstep(8'h34, 8'h0F, 4'd9);
    chk("R2 no match", cnt_rdata, 48'd0);
    gstep(8'h80, 8'h01, 4'd9);
    chk("R2 match", cnt_rdata, 48'd9);

    // R3 R4 R5 R6 sweep
    for (int ti = 0; ti < 6; ti++) begin
      for (int iv = 0; iv < 2; iv++) begin
        for (int ed = 0; ed < 2; ed++) begin
          int th;
          int exp;
          bit prev;
          case (ti)
            0: th = 0; 1: th = 1; 2: th = 3; 3: th = 8; 4: th = 15; default: th = 16;
          endcase
          exp = 0; prev = 0;
          start(pack(8'h80, 8'h0F, ed[0], iv[0], 1, th[4:0]));
          for (int i = 0; i < 30; i++) begin
            int c;
            int n;
            bit cond;
            logic [7:0] code;
            logic [7:0] sub;
            c = ((i / 3) * 5) % 16;
            code = (i % 7 == 6) ? 8'h81 : 8'h80;
            sub  = (i % 11 == 10) ? 8'hF0 : 8'h06;
            n = (code == 8'h80 && sub == 8'h06) ? c : 0;
            if (th == 0) cond = (n != 0);
            else if (iv == 1) cond = (n < th);
            else cond = (n >= th);
            if (ed == 1) exp += (cond && !prev) ? 1 : 0;
            else if (th != 0) exp += cond ? 1 : 0;
            else exp += n;
            prev = cond;
            gstep(code, sub, c[3:0]);
          end
          chk(ed == 1 ? "R6 edge sweep" : (th == 0 ? "R3 weighted sweep" : (iv == 1 ? "R5 inverted sweep" : "R4 threshold sweep")),
              cnt_rdata, 48'(exp));
          idle();
          wcfg(pack(8'h80, 8'h0F, ed[0], iv[0], 0, th[4:0]));
        end
      end
    end

    // R7 exhaustive unit mask against state and request pairs
    for (int u = 0; u < 256; u++) begin
      int exp;
      exp = 0;
      start(pack(8'h34, u[7:0], 0, 0, 1, 0));
      for (int s = 0; s < 4; s++) begin
        for (int r = 0; r < 4; r++) begin
          if (u[s] && u[4 + r]) exp++;
          lk_valid = 1'b1; lk_state = 4'(1 << s); lk_req = 4'(1 << r);
          @(negedge clk);
        end
      end
      idle();
      @(negedge clk);
      chk("R7 lookup", cnt_rdata, 48'(exp));
    end

    // R8 write priority over increment
    start(pack(8'h80, 8'h01, 0, 0, 1, 0));
    ev_code = 8'h80; ev_sub = 8'h01; ev_count = 4'd7;
    wcnt(48'h1234);
    chk("R8 priority", cnt_rdata, 48'h1234);
    idle();
    @(negedge clk);
    chk("R8 hold", cnt_rdata, 48'h1234);

    // R10 wrap
    wcnt(48'hFFFF_FFFF_FFFE);
    gstep(8'h80, 8'h01, 4'd3);
    chk("R10 wrap", cnt_rdata, 48'd1);

    // R9 freeze and history clear
    start(pack(8'h80, 8'h01, 1, 0, 1, 0));
    gstep(8'h80, 8'h01, 4'd5);
    gstep(8'h80, 8'h01, 4'd5);
    gstep(8'h80, 8'h01, 4'd5);
    chk("R6 single edge", cnt_rdata, 48'd1);
    wcfg(pack(8'h80, 8'h01, 1, 0, 0, 0));
    gstep(8'h80, 8'h01, 4'd5);
    gstep(8'h80, 8'h01, 4'd5);
    chk("R9 frozen", cnt_rdata, 48'd1);
    wcfg(pack(8'h80, 8'h01, 1, 0, 1, 0));
    gstep(8'h80, 8'h01, 4'd5);
    chk("R9 rearmed edge", cnt_rdata, 48'd2);

    // R5 invert ignored at zero threshold
    start(pack(8'h80, 8'h01, 0, 1, 1, 0));
    gstep(8'h80, 8'h01, 4'd4);
    gstep(8'h80, 8'h01, 4'd0);
    chk("R5 inv ignored", cnt_rdata, 48'd4);

    idle();
    @(negedge clk);
    finish_run();
  end
endmodule